// File: doc/BRIEF.md
# Partitioned Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from DMA channels, audio interfaces, interface groups and rate-detector units, and fans them out to up to five processor-facing interrupt lines, one per execution engine. Every resource belongs to exactly one engine, chosen through a map register. An engine sees only the events of the resources it owns.

Each engine has two levels of reporting. A set of per-class status registers records which resource raised which kind of event. A summary word has one bit per event class and shows which classes hold an enabled pending bit. The engine's interrupt line is the OR of its summary bits. Software reads the summary, reads the flagged class status, and clears the handled bits by writing ones to them.

Register addressing is 8 bits wide. Bit 7 = 0 selects the engine space: bits 6:4 hold the engine number, bit 3 picks status (0) or enable (1), and bits 2:0 hold the class code. Bit 7 = 1 selects the map space, where bits 6:0 are a flat resource index. Reads are combinational.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every status bit and every enable bit is 0, every resource is owned by engine 0, and all interrupt outputs are low.
- R2: An event pulse sets a sticky status bit at the clock edge that samples it. The bit is read at address eng*16+class, in bit position equal to the resource's index within its kind, and it stays set until it is cleared.
- R3: A status bit is visible only in the status registers of the engine that owns the resource. Other engines read 0 there and their interrupts are not raised by it. A rate-detector unit owns both its rate events and its variable-frame-rate events.
- R4: The map register of a resource is at address 0x80 plus the flat index (DMA channels first, then interfaces, then groups, then rate detectors). It holds the owning engine number. A write with a value of NUM_ENG or more is ignored.
- R5: Writing 1 to a status bit through its owning engine clears it. Zero bits in the write data have no effect, and a write through a non-owning engine has no effect.
- R6: When an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R7: The summary word is read at address eng*16+7. Its bit c is 1 when class c has a status bit that is both pending and enabled. The class codes are 0 DMA period, 1 DMA underflow/overflow, 2 bus error response, 3 interface underflow/overflow, 4 group done, 5 rate detector, 6 variable-frame-rate.
- R8: Each interrupt output is a level equal to the OR of its engine's summary bits. It rises right after the edge that samples the event and not before.
- R9: Each engine has an enable mask per class at address eng*16+8+class. Bits outside the class's resource count read 0. A disabled pending bit still shows in status, and enabling it later raises the summary bit and the interrupt.
- R10: Changing the owner of a resource moves that resource's pending status bits to the new engine.
- R11: Reads of unused addresses return 0. This covers engine numbers of NUM_ENG or more, enable slot 7 and map indices past the last resource.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| ev_dma_period_i | input | NUM_DMA | DMA period events |
| ev_dma_xrun_i | input | NUM_DMA | DMA underflow/overflow events |
| ev_bus_err_i | input | NUM_DMA | DMA bus error response events |
| ev_if_xrun_i | input | NUM_IF | Interface underflow/overflow events |
| ev_grp_done_i | input | NUM_GRP | Interface group done events |
| ev_rate_i | input | NUM_RATE | Rate detector events |
| ev_vfr_i | input | NUM_RATE | Variable-frame-rate events |
| irq_o | output | NUM_ENG | Level interrupt per engine |

## Verification
Status bits, summary bits and interrupts all change at the single edge that samples an event pulse or a write strobe. There is one register stage on every path. Register reads are combinational and reflect that state in the same cycle. The bench therefore drives stimulus at the falling edge and lets exactly one rising edge pass. It then samples one nanosecond later. The interrupt timing check also samples just before that edge, to show the line has not risen early.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NCLS   = 7;
  localparam int ENG_W  = 3;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [2:0] SLOT_SUMMARY = 3'd7;

  typedef enum logic [2:0] {
    CLS_DMA_PERIOD = 3'd0,
    CLS_DMA_XRUN   = 3'd1,
    CLS_BUS_ERR    = 3'd2,
    CLS_IF_XRUN    = 3'd3,
    CLS_GRP_DONE   = 3'd4,
    CLS_RATE       = 3'd5,
    CLS_VFR        = 3'd6
  } ev_class_e;

  typedef enum logic [1:0] {RK_DMA, RK_IF, RK_GRP, RK_RATE} res_kind_e;

  // Engine space: {0, eng[2:0], en_bank, slot[2:0]}; map space: {1, index[6:0]}
  typedef struct packed {
    logic       map_sel;
    logic [2:0] eng;
    logic       en_bank;
    logic [2:0] slot;
  } reg_addr_t;

  function automatic res_kind_e kind_of(input int cls);
    if (cls <= 2)      return RK_DMA;
    else if (cls == 3) return RK_IF;
    else if (cls == 4) return RK_GRP;
    else               return RK_RATE;
  endfunction

  function automatic int kind_count(input res_kind_e k, input int nd, input int ni,
                                    input int ng, input int nr);
    case (k)
      RK_DMA:  return nd;
      RK_IF:   return ni;
      RK_GRP:  return ng;
      default: return nr;
    endcase
  endfunction

  // Flat resource index of bit 0 of a kind in the map space
  function automatic int kind_base(input res_kind_e k, input int nd, input int ni,
                                   input int ng);
    case (k)
      RK_DMA:  return 0;
      RK_IF:   return nd;
      RK_GRP:  return nd + ni;
      default: return nd + ni + ng;
    endcase
  endfunction

  function automatic int max_width(input int nd, input int ni, input int ng, input int nr);
    int m;
    m = nd;
    if (ni > m) m = ni;
    if (ng > m) m = ng;
    if (nr > m) m = nr;
    return m;
  endfunction

  // Sticky bit update: a new event outranks a clear in the same cycle
  function automatic logic [DATA_W-1:0] sticky_next(input logic [DATA_W-1:0] stat,
                                                    input logic [DATA_W-1:0] ev,
                                                    input logic [DATA_W-1:0] clr);
    return (stat & ~clr) | ev;
  endfunction
endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status
  import irq_agg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= W'(sticky_next(DATA_W'(stat_q), DATA_W'(ev_i), DATA_W'(clr_i)));
  end

  assign stat_o = stat_q;

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));

  assert_clear_only_on_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_i)) == '0));
endmodule

// File: rtl/irq_agg_owner.sv
module irq_agg_owner
  import irq_agg_pkg::*;
#(
  parameter int NENG = 5,
  parameter int NRES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [6:0]                   idx_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [NRES-1:0][ENG_W-1:0]   owner_o
);
  localparam logic [ENG_W-1:0] ENG_LAST = ENG_W'(NENG - 1);

  logic [NRES-1:0][ENG_W-1:0] owner_q;
  logic                       accept;

  assign accept = wr_i && (int'(idx_i) < NRES) && (data_i < DATA_W'(NENG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else begin
      for (int r = 0; r < NRES; r++)
        if (accept && idx_i == 7'(r)) owner_q[r] <= data_i[ENG_W-1:0];
    end
  end

  assign owner_o = owner_q;

  assert_reject_bad_engine_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && data_i >= DATA_W'(NENG)) |=> $stable(owner_q));

  for (genvar r = 0; r < NRES; r++) begin : g_rng
    assert_owner_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      owner_q[r] <= ENG_LAST);
  end
endmodule

// File: rtl/irq_agg_engine.sv
module irq_agg_engine
  import irq_agg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       any_wr_i,
  input  logic                       en_we_i,
  input  logic [2:0]                 en_slot_i,
  input  logic [W-1:0]               en_wdata_i,
  input  logic [NCLS-1:0][W-1:0]     valid_i,
  input  logic [NCLS-1:0][W-1:0]     view_i,
  output logic [NCLS-1:0][W-1:0]     enable_o,
  output logic [NCLS-1:0]            summary_o,
  output logic                       irq_o
);
  logic [NCLS-1:0][W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      for (int c = 0; c < NCLS; c++)
        if (en_we_i && en_slot_i == 3'(c)) en_q[c] <= en_wdata_i & valid_i[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) summary_o[c] = |(view_i[c] & en_q[c]);
  end

  assign irq_o    = |summary_o;
  assign enable_o = en_q;

  // Status only clears, masks only change and owners only move on a write
  assert_irq_fall_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(any_wr_i));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_ENG  = 5,
  parameter int NUM_DMA  = 8,
  parameter int NUM_IF   = 4,
  parameter int NUM_GRP  = 2,
  parameter int NUM_RATE = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [NUM_DMA-1:0]  ev_dma_period_i,
  input  logic [NUM_DMA-1:0]  ev_dma_xrun_i,
  input  logic [NUM_DMA-1:0]  ev_bus_err_i,
  input  logic [NUM_IF-1:0]   ev_if_xrun_i,
  input  logic [NUM_GRP-1:0]  ev_grp_done_i,
  input  logic [NUM_RATE-1:0] ev_rate_i,
  input  logic [NUM_RATE-1:0] ev_vfr_i,
  output logic [NUM_ENG-1:0]  irq_o
);
  localparam int NRES = NUM_DMA + NUM_IF + NUM_GRP + NUM_RATE;
  localparam int W    = max_width(NUM_DMA, NUM_IF, NUM_GRP, NUM_RATE);

  reg_addr_t                              a;
  logic [NCLS-1:0][W-1:0]                 ev_all, clr_all, stat_all, valid;
  logic [NCLS-1:0][W-1:0][ENG_W-1:0]      own_cb;
  logic [NRES-1:0][ENG_W-1:0]             owner;
  logic [NUM_ENG-1:0][NCLS-1:0][W-1:0]    view, en_all;
  logic [NUM_ENG-1:0][NCLS-1:0]           summ_all;
  logic                                   stat_wr;

  assign a       = reg_addr_t'(reg_addr_i);
  assign stat_wr = reg_wr_i && !a.map_sel && !a.en_bank;

  always_comb begin
    ev_all = '0;
    ev_all[CLS_DMA_PERIOD][NUM_DMA-1:0] = ev_dma_period_i;
    ev_all[CLS_DMA_XRUN][NUM_DMA-1:0]   = ev_dma_xrun_i;
    ev_all[CLS_BUS_ERR][NUM_DMA-1:0]    = ev_bus_err_i;
    ev_all[CLS_IF_XRUN][NUM_IF-1:0]     = ev_if_xrun_i;
    ev_all[CLS_GRP_DONE][NUM_GRP-1:0]   = ev_grp_done_i;
    ev_all[CLS_RATE][NUM_RATE-1:0]      = ev_rate_i;
    ev_all[CLS_VFR][NUM_RATE-1:0]       = ev_vfr_i;
  end

  irq_agg_owner #(.NENG(NUM_ENG), .NRES(NRES)) u_owner (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i && a.map_sel),
    .idx_i(reg_addr_i[6:0]), .data_i(reg_wdata_i), .owner_o(owner)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    localparam res_kind_e K    = kind_of(c);
    localparam int        CNT  = kind_count(K, NUM_DMA, NUM_IF, NUM_GRP, NUM_RATE);
    localparam int        BASE = kind_base(K, NUM_DMA, NUM_IF, NUM_GRP);

    for (genvar b = 0; b < W; b++) begin : g_bit
      if (b < CNT) begin : g_real
        assign own_cb[c][b] = owner[BASE + b];
        assign valid[c][b]  = 1'b1;
      end else begin : g_pad
        assign own_cb[c][b] = '0;
        assign valid[c][b]  = 1'b0;
      end
      assign clr_all[c][b] = stat_wr && (a.slot == 3'(c)) && reg_wdata_i[b]
                             && valid[c][b] && (own_cb[c][b] == a.eng);

      logic [NUM_ENG-1:0] vis;
      for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        assign view[e][c][b] = stat_all[c][b] && valid[c][b] && (own_cb[c][b] == ENG_W'(e));
        assign vis[e]        = view[e][c][b];
      end
      assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vis));
    end

    irq_agg_status #(.W(W)) u_stat (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_all[c]), .clr_i(clr_all[c]), .stat_o(stat_all[c])
    );
  end

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_engine
    irq_agg_engine #(.W(W)) u_eng (
      .clk(clk), .rst_n(rst_n), .any_wr_i(reg_wr_i),
      .en_we_i(reg_wr_i && !a.map_sel && a.en_bank && a.eng == ENG_W'(e)),
      .en_slot_i(a.slot), .en_wdata_i(reg_wdata_i[W-1:0]), .valid_i(valid),
      .view_i(view[e]), .enable_o(en_all[e]), .summary_o(summ_all[e]), .irq_o(irq_o[e])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (a.map_sel) begin
      if (int'(reg_addr_i[6:0]) < NRES) reg_rdata_o = DATA_W'(owner[reg_addr_i[6:0]]);
    end else if (int'(a.eng) < NUM_ENG) begin
      if (a.en_bank) begin
        if (a.slot != SLOT_SUMMARY) reg_rdata_o = DATA_W'(en_all[a.eng][a.slot]);
      end else if (a.slot == SLOT_SUMMARY) begin
        reg_rdata_o = DATA_W'(summ_all[a.eng]);
      end else begin
        reg_rdata_o = DATA_W'(view[a.eng][a.slot]);
      end
    end
  end
endmodule

// File: tb/irq_agg_top_bench.sv
`timescale 1ns/1ps
module irq_agg_top_bench;
  localparam int NE = 5, ND = 8, NI = 4, NG = 2, NR = 2;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;   // for OP_EV: class code
    logic [31:0] data;   // write data, expected read data, or event mask
    logic [4:0]  irq;    // expected irq_o on OP_RD
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 4'd4,  8'h83, 32'h2,  5'b00000}, // R4 DMA3 -> engine 2
    '{OP_WR, 4'd9,  8'h28, 32'hFF, 5'b00000}, // R9 eng2 DMA period enable
    '{OP_EV, 4'd2,  8'h00, 32'h08, 5'b00000}, // R2 DMA3 period
    '{OP_RD, 4'd2,  8'h20, 32'h08, 5'b00100}, // R2
    '{OP_RD, 4'd3,  8'h00, 32'h00, 5'b00100}, // R3 hidden from eng0
    '{OP_RD, 4'd7,  8'h27, 32'h01, 5'b00100}, // R7
    '{OP_EV, 4'd9,  8'h00, 32'h01, 5'b00000}, // DMA0 period, eng0 masked
    '{OP_RD, 4'd9,  8'h00, 32'h01, 5'b00100}, // R9 latched, no irq
    '{OP_WR, 4'd9,  8'h08, 32'h01, 5'b00000},
    '{OP_RD, 4'd9,  8'h07, 32'h01, 5'b00101}, // R9 enabling raises
    '{OP_WR, 4'd5,  8'h00, 32'h08, 5'b00000}, // clear via non-owner
    '{OP_RD, 4'd5,  8'h20, 32'h08, 5'b00101}, // R5 unaffected
    '{OP_WR, 4'd5,  8'h20, 32'h08, 5'b00000},
    '{OP_RD, 4'd5,  8'h20, 32'h00, 5'b00001}, // R5 cleared
    '{OP_WR, 4'd5,  8'h00, 32'h00, 5'b00000},
    '{OP_RD, 4'd5,  8'h00, 32'h01, 5'b00001}, // R5 zero write no effect
    '{OP_WR, 4'd5,  8'h00, 32'hFF, 5'b00000},
    '{OP_RD, 4'd8,  8'h00, 32'h00, 5'b00000}, // R8 irq drops
    '{OP_WR, 4'd4,  8'h89, 32'h4,  5'b00000}, // IF1 -> engine 4
    '{OP_WR, 4'd9,  8'h4B, 32'h0F, 5'b00000},
    '{OP_EV, 4'd2,  8'h03, 32'h02, 5'b00000},
    '{OP_RD, 4'd2,  8'h43, 32'h02, 5'b10000}, // R2
    '{OP_RD, 4'd7,  8'h47, 32'h08, 5'b10000}, // R7 class 3
    '{OP_WR, 4'd4,  8'h8F, 32'h1,  5'b00000}, // rate1 -> engine 1
    '{OP_WR, 4'd9,  8'h1E, 32'h03, 5'b00000},
    '{OP_EV, 4'd3,  8'h06, 32'h02, 5'b00000},
    '{OP_RD, 4'd3,  8'h16, 32'h02, 5'b10010}, // R3 VFR follows rate owner
    '{OP_RD, 4'd7,  8'h17, 32'h40, 5'b10010}, // R7 class 6
    '{OP_EV, 4'd3,  8'h05, 32'h02, 5'b00000},
    '{OP_RD, 4'd3,  8'h15, 32'h02, 5'b10010}, // R3
    '{OP_RD, 4'd9,  8'h17, 32'h40, 5'b10010}, // R9 class 5 masked
    '{OP_EV, 4'd2,  8'h04, 32'h01, 5'b00000},
    '{OP_WR, 4'd9,  8'h0C, 32'h03, 5'b00000},
    '{OP_RD, 4'd7,  8'h07, 32'h10, 5'b10011}, // R7 class 4
    '{OP_WR, 4'd9,  8'h2A, 32'h08, 5'b00000},
    '{OP_EV, 4'd2,  8'h02, 32'h08, 5'b00000},
    '{OP_RD, 4'd7,  8'h27, 32'h04, 5'b10111}, // R7 class 2
    '{OP_RD, 4'd11, 8'h50, 32'h00, 5'b10111}, // R11 engine 5
    '{OP_RD, 4'd11, 8'h9F, 32'h00, 5'b10111}, // R11 map index 31
    '{OP_RD, 4'd4,  8'h83, 32'h02, 5'b10111}, // R4 readback
    '{OP_RD, 4'd9,  8'h0C, 32'h03, 5'b10111}, // R9
    '{OP_RD, 4'd9,  8'h4B, 32'h0F, 5'b10111}  // R9
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [ND-1:0] ev_dma_period = '0, ev_dma_xrun = '0, ev_bus_err = '0;
  logic [NI-1:0] ev_if_xrun = '0;
  logic [NG-1:0] ev_grp_done = '0;
  logic [NR-1:0] ev_rate = '0, ev_vfr = '0;
  logic [NE-1:0] irq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  irq_agg_top u_irq_agg_top (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr_en), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .ev_dma_period_i(ev_dma_period), .ev_dma_xrun_i(ev_dma_xrun),
    .ev_bus_err_i(ev_bus_err), .ev_if_xrun_i(ev_if_xrun), .ev_grp_done_i(ev_grp_done),
    .ev_rate_i(ev_rate), .ev_vfr_i(ev_vfr), .irq_o(irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drive_ev(input logic [2:0] cls, input logic [31:0] m);
    case (cls)
      3'd0: ev_dma_period = m[ND-1:0];
      3'd1: ev_dma_xrun   = m[ND-1:0];
      3'd2: ev_bus_err    = m[ND-1:0];
      3'd3: ev_if_xrun    = m[NI-1:0];
      3'd4: ev_grp_done   = m[NG-1:0];
      3'd5: ev_rate       = m[NR-1:0];
      default: ev_vfr     = m[NR-1:0];
    endcase
  endtask

  task automatic clear_ev();
    ev_dma_period = '0; ev_dma_xrun = '0; ev_bus_err = '0; ev_if_xrun = '0;
    ev_grp_done = '0; ev_rate = '0; ev_vfr = '0;
  endtask

  task automatic pulse(input logic [2:0] cls, input logic [31:0] m);
    @(negedge clk); drive_ev(cls, m);
    @(negedge clk); clear_ev();
  endtask

  task automatic check_rd(input logic [7:0] a, input logic [31:0] exp,
                          input logic [4:0] exp_irq, input int req);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
    check(req, 32'(irq), 32'(exp_irq));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_rd(8'h00, 32'h0, 5'b00000, 1);
    check_rd(8'h08, 32'h0, 5'b00000, 1);
    check_rd(8'h83, 32'h0, 5'b00000, 1);
    check_rd(8'h47, 32'h0, 5'b00000, 1);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   do_write(VECS[i].addr, VECS[i].data);
        OP_EV:   pulse(VECS[i].addr[2:0], VECS[i].data);
        default: check_rd(VECS[i].addr, VECS[i].data, VECS[i].irq, int'(VECS[i].req));
      endcase
    end

    // R6 event and clear in the same cycle
    do_write(8'h09, 32'hFF);
    pulse(3'd1, 32'h01);
    @(negedge clk); addr = 8'h01; wdata = 32'h01; wr_en = 1'b1; ev_dma_xrun = 8'h01;
    @(negedge clk); wr_en = 1'b0; clear_ev();
    check_rd(8'h01, 32'h01, 5'b10111, 6);
    do_write(8'h01, 32'h01);
    check_rd(8'h01, 32'h00, 5'b10111, 6); // R5

    // R8 edge timing of the interrupt line
    do_write(8'h85, 32'h3);
    do_write(8'h39, 32'hFF);
    @(negedge clk); ev_dma_xrun = 8'h20; #1;
    check(8, 32'(irq[3]), 32'h0);
    @(posedge clk); #1;
    check(8, 32'(irq[3]), 32'h1);
    @(negedge clk); clear_ev();
    check_rd(8'h31, 32'h20, 5'b11111, 8);

    // R10 remap moves pending status
    do_write(8'h85, 32'h0);
    check_rd(8'h01, 32'h20, 5'b10111, 10);
    check_rd(8'h31, 32'h00, 5'b10111, 10);

    // R4 out-of-range engine numbers ignored
    do_write(8'h80, 32'h5);
    check_rd(8'h80, 32'h0, 5'b10111, 4);
    do_write(8'h80, 32'h0001_0002);
    check_rd(8'h80, 32'h0, 5'b10111, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule